// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a 24-line general purpose parallel I/O peripheral that hangs off a simple CPU bus. The bus side carries an 8-bit write data input, a registered read data output with a separate drive-enable (standing in for a three-state buffer), an active-low select, active-low read and write strobes and a 2-bit register select. On the device side there are three 8-bit ports, A, B and C. Port C is handled as two 4-bit halves, each with its own direction.

Software configures the block with a single command register address. The most significant bit of a command chooses between two kinds of command. One is a configuration word that sets the directions and records the group modes. The other is a single-bit set or clear of a port C output latch. Ports that are outputs drive their latched value and report it when read. Ports that are inputs report the live pin levels. Only basic unstrobed input/output is provided. Mode fields for the handshaking modes are stored and read back, but they do not change port behaviour.

All logic is synchronous to one clock. A write commits in the clock cycle in which the sampled write strobe returns high while the select is still low. A read returns data one clock after select and read strobe are both seen low.

Top module: `ppi_core`

## Requirements
- R1: Register select 0 addresses port A, 1 addresses port B, 2 addresses port C, and 3 addresses the command register, for both reads and writes.
- R2: `bus_oe` is 1 in the cycle after a clock edge that samples `cs_n`=0 and `rd_n`=0, and is 0 (with `bus_rdata`=0) after any other edge.
- R3: Synchronous reset makes every port an input (all output enables 0), clears all output latches and sets the command register so that it reads back as 0x9B.
- R4: A configuration word (bit 7 = 1) sets the directions, where 1 means input. Bit 4 controls port A, bit 3 controls port C bits 7:4, bit 1 controls port B and bit 0 controls port C bits 3:0. An output enable is 1 exactly for output lines.
- R5: Committing a configuration word clears the port A, B and C output latches to zero.
- R6: A set/clear command (bit 7 = 0) writes bit 0 into port C latch bit number {bit3,bit2,bit1}. Bits 6:4 are ignored, and the command register and directions are unchanged.
- R7: Reading the command register returns bit 7 as 1 and bits 6:0 as last written by a configuration word, mode fields included.
- R8: Reading an output port returns its latch. Reading an input port returns the pin levels present at the read's sampling edge, with no latching.
- R9: Each port C half is read according to its own direction bit, so one read can mix latched and live bits.
- R10: A write commits only on a rising write strobe seen while `cs_n` is low. A strobe that rises together with `cs_n`, or while `cs_n` is high, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low block select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| reg_sel | input | 2 | Register select (A, B, C, command) |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rdata | output | 8 | Registered read data |
| bus_oe | output | 1 | Read data drive enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-line output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-line output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-line output enable |

## Verification
A set/clear command into the output half of port C can commit in the same clock in which the pins of the input half of port C change. The bench raises the write strobe and changes `pc_in` at the same falling edge. It then reads port C and expects the new latch bits in the low half and the new pin levels in the high half. A configuration word can also arrive while the port latches hold data, so its clearing of the latches is judged at the port outputs and by reading the latches back.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int BIT_SW = $clog2(DATA_W);
  localparam int CTRL_W = DATA_W - 1;

  typedef enum logic [1:0] {
    SEL_PA  = 2'd0,
    SEL_PB  = 2'd1,
    SEL_PC  = 2'd2,
    SEL_CMD = 2'd3
  } port_sel_e;

  // Command register field positions (bit 7 chooses command kind).
  localparam int CMD_KIND   = 7;
  localparam int DIR_A      = 4;
  localparam int DIR_CHI    = 3;
  localparam int DIR_B      = 1;
  localparam int DIR_CLO    = 0;
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'h1B;
endpackage

// File: rtl/ppi_wr_detect.sv
module ppi_wr_detect (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic wr_n,
  output logic wr_fire
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  // Rising strobe while still selected.
  assign wr_fire = !wr_q && wr_n && !cs_n;
endmodule

// File: rtl/ppi_cfg.sv
module ppi_cfg
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  port_sel_e         wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] pa_lat,
  output logic [DATA_W-1:0] pb_lat,
  output logic [DATA_W-1:0] pc_lat,
  output logic [DATA_W-1:0] pa_oe,
  output logic [DATA_W-1:0] pb_oe,
  output logic [DATA_W-1:0] pc_oe
);
  logic [BIT_SW-1:0] bit_idx;
  logic [1:0]        c_dir;

  assign bit_idx = wr_data[BIT_SW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= CTRL_RST;
      pa_lat <= '0;
      pb_lat <= '0;
      pc_lat <= '0;
    end else if (wr_fire) begin
      unique case (wr_sel)
        SEL_PA: pa_lat <= wr_data;
        SEL_PB: pb_lat <= wr_data;
        SEL_PC: pc_lat <= wr_data;
        SEL_CMD: begin
          if (wr_data[CMD_KIND]) begin
            ctrl   <= wr_data[CTRL_W-1:0];
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
          end else begin
            pc_lat[bit_idx] <= wr_data[0];
          end
        end
        default: ;
      endcase
    end
  end

  assign pa_oe = {DATA_W{~ctrl[DIR_A]}};
  assign pb_oe = {DATA_W{~ctrl[DIR_B]}};
  assign c_dir = {ctrl[DIR_CHI], ctrl[DIR_CLO]};

  for (genvar g = 0; g < 2; g++) begin : g_cnib
    assign pc_oe[g*NIB_W +: NIB_W] = {NIB_W{~c_dir[g]}};
  end
endmodule

// File: rtl/ppi_rd_path.sv
module ppi_rd_path
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  port_sel_e         rd_sel,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] pa_lat,
  input  logic [DATA_W-1:0] pb_lat,
  input  logic [DATA_W-1:0] pc_lat,
  input  logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_oe,
  input  logic [DATA_W-1:0] pc_oe,
  input  logic [DATA_W-1:0] pa_in,
  input  logic [DATA_W-1:0] pb_in,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] pa_view, pb_view, pc_view, mux;

  // Per line: output lines return the latch, input lines the pins.
  assign pa_view = (pa_oe & pa_lat) | (~pa_oe & pa_in);
  assign pb_view = (pb_oe & pb_lat) | (~pb_oe & pb_in);
  assign pc_view = (pc_oe & pc_lat) | (~pc_oe & pc_in);

  always_comb begin
    unique case (rd_sel)
      SEL_PA:  mux = pa_view;
      SEL_PB:  mux = pb_view;
      SEL_PC:  mux = pc_view;
      default: mux = {1'b1, ctrl};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n || rd_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= mux;
      rvalid <= 1'b1;
    end
  end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] pc_oe
);
  logic              wr_fire;
  logic [CTRL_W-1:0] ctrl;
  port_sel_e         sel_e;

  assign sel_e = port_sel_e'(reg_sel);

  ppi_wr_detect u_wr (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .wr_fire (wr_fire)
  );

  ppi_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .wr_sel  (sel_e),
    .wr_data (bus_wdata),
    .ctrl    (ctrl),
    .pa_lat  (pa_out),
    .pb_lat  (pb_out),
    .pc_lat  (pc_out),
    .pa_oe   (pa_oe),
    .pb_oe   (pb_oe),
    .pc_oe   (pc_oe)
  );

  ppi_rd_path u_rd (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .rd_sel (sel_e),
    .ctrl   (ctrl),
    .pa_lat (pa_out),
    .pb_lat (pb_out),
    .pc_lat (pc_out),
    .pa_oe  (pa_oe),
    .pb_oe  (pb_oe),
    .pc_oe  (pc_oe),
    .pa_in  (pa_in),
    .pb_in  (pb_in),
    .pc_in  (pc_in),
    .rdata  (bus_rdata),
    .rvalid (bus_oe)
  );
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] reg_sel,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       bus_oe,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  logic wr_seen_q;
  logic commit;

  always_ff @(posedge clk) begin
    if (rst) wr_seen_q <= 1'b1;
    else     wr_seen_q <= wr_n;
  end

  assign commit = !wr_seen_q && wr_n && !cs_n;

  AST_RD_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |=> bus_oe) else $error("rd enable");                     // R2

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !rd_n == 1'b0) |=> (!bus_oe && bus_rdata == 8'h00)) else $error("bus quiet"); // R2

  AST_CMD_MSB_SET: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && reg_sel == 2'd3) |=> bus_rdata[7]) else $error("cmd msb"); // R7

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                 $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))) else $error("stray"); // R10

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (commit && reg_sel == 2'd3 && bus_wdata[7]) |=>
      (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)) else $error("clear"); // R5

  AST_BITCMD_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
    (commit && reg_sel == 2'd3 && !bus_wdata[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
       $countones(pc_out ^ $past(pc_out)) <= 1)) else $error("bitcmd"); // R6

  AST_HALF_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    ((pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF) &&
     (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF))) else $error("half"); // R4
endmodule

bind ppi_core ppi_core_chk u_chk (.*);

// File: tb/tb_ppi_core.sv
module tb_ppi_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // Requirement-level model.
  logic [6:0] m_ctrl = 7'h1B;
  logic [7:0] m_a = 8'h00, m_b = 8'h00, m_c = 8'h00;

  ppi_core dut (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_oe_a(); return {8{~m_ctrl[4]}}; endfunction
  function automatic logic [7:0] m_oe_b(); return {8{~m_ctrl[1]}}; endfunction
  function automatic logic [7:0] m_oe_c(); return {{4{~m_ctrl[3]}}, {4{~m_ctrl[0]}}}; endfunction

  function automatic logic [7:0] model_read(logic [1:0] s);
    case (s)
      2'd0:    return (m_oe_a() & m_a) | (~m_oe_a() & pa_in);
      2'd1:    return (m_oe_b() & m_b) | (~m_oe_b() & pb_in);
      2'd2:    return (m_oe_c() & m_c) | (~m_oe_c() & pc_in);
      default: return {1'b1, m_ctrl};
    endcase
  endfunction

  // Driver: one read cycle, expectation pushed to the scoreboard.
  task automatic bus_read(logic [1:0] s, string req);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; reg_sel = s;
    exp_q.push_back(model_read(s));
    tag_q.push_back(req);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic model_commit(logic [1:0] s, logic [7:0] d);
    case (s)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default: begin
        if (d[7]) begin
          m_ctrl = d[6:0]; m_a = 0; m_b = 0; m_c = 0;
        end else m_c[d[3:1]] = d[0];
      end
    endcase
  endtask

  task automatic bus_write(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; reg_sel = s; bus_wdata = d;
    @(negedge clk);
    wr_n = 1'b1;
    model_commit(s, d);
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic check_ports(string req);
    check(req, pa_out, m_a);
    check(req, pb_out, m_b);
    check(req, pc_out, m_c);
    check(req, pa_oe, m_oe_a());
    check(req, pb_oe, m_oe_b());
    check(req, pc_oe, m_oe_c());
  endtask

  // Monitor: pops expectations as read data appears.
  always @(negedge clk) begin
    if (!rst && bus_oe) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected read expected none");
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3 reset state
    check_ports("R3");
    check("R2", bus_oe, 1'b0);
    bus_read(2'd3, "R3 R7 cmd reset value");
    check("R3", model_read(2'd3), 8'h9B);

    // R1 R8 inputs read live pins
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h7E;
    bus_read(2'd0, "R1 R8 port A pins");
    bus_read(2'd1, "R1 R8 port B pins");
    bus_read(2'd2, "R1 R8 port C pins");
    pa_in = 8'hA5;
    bus_read(2'd0, "R8 port A new pins");

    // R4 all outputs; latches
    bus_write(2'd3, 8'h80);
    check_ports("R4");
    bus_write(2'd0, 8'h11);
    bus_write(2'd1, 8'h22);
    bus_write(2'd2, 8'h33);
    check_ports("R8");
    bus_read(2'd0, "R1 R8 port A latch");
    bus_read(2'd1, "R1 R8 port B latch");
    bus_read(2'd2, "R1 R8 port C latch");

    // R5 clearing, R4 mixed port C directions (upper in, lower out)
    bus_write(2'd3, 8'h88);
    check_ports("R5");
    check("R5", pa_out, 8'h00);

    // R6 set/clear, ignored bits 6:4
    bus_write(2'd3, 8'h07);
    bus_write(2'd3, 8'h75);
    check_ports("R6");
    check("R6", pc_out, 8'h0C);
    bus_read(2'd3, "R6 R7 cmd unchanged");

    // R9 mixed read
    pc_in = 8'hA5;
    bus_read(2'd2, "R9 mixed port C");

    // Same-cycle: set/clear commit and input-half pin change
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; reg_sel = 2'd3; bus_wdata = 8'h06;
    @(negedge clk);
    wr_n = 1'b1; pc_in = 8'h50;
    model_commit(2'd3, 8'h06);
    @(negedge clk);
    cs_n = 1'b1;
    check("R6", pc_out, 8'h04);
    bus_read(2'd2, "R9 R6 same-cycle port C");

    // R10 aborted and deselected writes
    bus_write(2'd0, 8'h99);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; reg_sel = 2'd0; bus_wdata = 8'h44;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check("R10 strobe with deselect", pa_out, 8'h99);
    @(negedge clk);
    wr_n = 1'b0; reg_sel = 2'd3; bus_wdata = 8'h9B;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    check_ports("R10 deselected");
    bus_read(2'd0, "R10 port A latch kept");

    // R2 selected but idle
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    check("R2 idle select", bus_oe, 1'b0);
    cs_n = 1'b1;

    // R7 mode fields read back, R5 clearing again
    bus_write(2'd1, 8'h6D);
    bus_write(2'd3, 8'hE5);
    check_ports("R5 R7");
    bus_read(2'd3, "R7 mode fields");
    pb_in = 8'h3C;
    bus_read(2'd1, "R4 port B output latch");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule